// File: doc/BRIEF.md
# Pulse Decoder with Silence Watchdog

This block is the receiving half of a one-bit isolated link. The sending half sends a "set" pulse when its input goes high and a "clear" pulse when it goes low. It also repeats the pulse for the current level at a steady refresh rate. The receiver stores the last level it decoded in a bistable element and presents that level on its data output.

A watchdog counts clock cycles since the last pulse it accepted. If the link stays quiet for `TIMEOUT_CYCLES` cycles, the block decides that the sending side has lost power or failed. It then raises a link-lost flag and drives the data output high, whatever level it last decoded. The first pulse it accepts after that clears the flag, and the output takes that pulse's level at once. `TIMEOUT_CYCLES` should cover several refresh periods, so that a single late refresh does not trip the watchdog.

Both pulse inputs are sampled on every rising clock edge. A cycle in which exactly one of them is high counts as a pulse. A cycle in which both are high is treated as corrupt and discarded.

Top module: `pulse_link_receiver`

## Requirements
- R1: While `rst` is high and in every cycle after it, until the first accepted pulse, `data_o` is 1 and `link_lost_o` is 1.
- R2: A cycle with `set_pulse_i`=1 and `clr_pulse_i`=0 makes `data_o` 1 from the next clock edge onward.
- R3: A cycle with `clr_pulse_i`=1 and `set_pulse_i`=0 makes `data_o` 0 from the next clock edge onward, unless the link is later declared lost.
- R4: In a cycle with neither pulse input high and the link not timing out, `data_o` keeps its value.
- R5: A cycle with both pulse inputs high is ignored entirely. The decoded level does not change and the watchdog is not reloaded.
- R6: `link_lost_o` rises exactly `TIMEOUT_CYCLES` clock edges after the edge that accepted the last pulse, provided no pulse is accepted in between. It does not rise at any other time.
- R7: While `link_lost_o` is 1, `data_o` is 1.
- R8: An accepted pulse while the link is lost clears `link_lost_o` at the next edge, and `data_o` takes that pulse's level at the same edge.
- R9: Refresh pulses that arrive closer together than `TIMEOUT_CYCLES` keep `link_lost_o` at 0 and keep `data_o` steady when they repeat the same level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| set_pulse_i | input | 1 | Set pulse from the link, requests a high level |
| clr_pulse_i | input | 1 | Clear pulse from the link, requests a low level |
| data_o | output | 1 | Decoded data level, forced high while the link is lost |
| link_lost_o | output | 1 | High while no pulse has been accepted within the timeout |

## Verification
The assertions check several rules on every cycle:
- each accepted pulse sets the stored level and clears the flag one edge later;
- the stored level stays put on idle and conflicting cycles;
- the flag never rises in a cycle that carries a pulse;
- the flag always matches an independent count of quiet cycles, which fixes the exact timeout edge.

Some behaviour only shows up in the bench's scenarios:
- the output being forced high once the timeout has expired;
- recovery to the correct level on the first pulse after a silence;
- a conflicting cycle leaving the timeout schedule untouched;
- a steady refresh train holding the link up across many windows.

// File: rtl/pdec_pkg.sv
package pdec_pkg;

  // Meaning of one sampled cycle of the two pulse inputs
  typedef enum logic [1:0] {
    EV_NONE     = 2'd0,
    EV_SET      = 2'd1,
    EV_CLR      = 2'd2,
    EV_CONFLICT = 2'd3
  } pulse_ev_e;

  function automatic pulse_ev_e classify_pulse(input logic set_p, input logic clr_p);
    pulse_ev_e ev;
    unique case ({set_p, clr_p})
      2'b10:   ev = EV_SET;
      2'b01:   ev = EV_CLR;
      2'b11:   ev = EV_CONFLICT;
      default: ev = EV_NONE;
    endcase
    return ev;
  endfunction

  // Only a single-polarity cycle is an accepted pulse
  function automatic logic pulse_accepted(input pulse_ev_e ev);
    return (ev == EV_SET) || (ev == EV_CLR);
  endfunction

  function automatic logic pulse_level(input pulse_ev_e ev);
    return (ev == EV_SET);
  endfunction

  // Failsafe level: a silent link reads as high
  function automatic logic failsafe_level(input logic lost, input logic held);
    return lost | held;
  endfunction

endpackage

// File: rtl/pdec_classifier.sv
module pdec_classifier
  import pdec_pkg::*;
(
  input  logic      set_pulse_i,
  input  logic      clr_pulse_i,
  output pulse_ev_e ev_o,
  output logic      accept_o,
  output logic      level_o
);

  pulse_ev_e ev;

  always_comb begin
    ev       = classify_pulse(set_pulse_i, clr_pulse_i);
    ev_o     = ev;
    accept_o = pulse_accepted(ev);
    level_o  = pulse_level(ev);
  end

endmodule

// File: rtl/pdec_hold_latch.sv
module pdec_hold_latch
  import pdec_pkg::*;
#(
  parameter logic RESET_LEVEL = 1'b1
) (
  input  logic      clk,
  input  logic      rst,
  input  pulse_ev_e ev_i,
  input  logic      accept_i,
  input  logic      level_i,
  output logic      held_o
);

  logic held_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= RESET_LEVEL;
    end else if (accept_i) begin
      held_q <= level_i;
    end
  end

  assign held_o = held_q;

  // R2: a set pulse stores a high level
  assert_set_stores_high_R2: assert property (@(posedge clk) disable iff (rst)
    (ev_i == EV_SET) |=> held_q);

  // R3: a clear pulse stores a low level
  assert_clr_stores_low_R3: assert property (@(posedge clk) disable iff (rst)
    (ev_i == EV_CLR) |=> !held_q);

  // R4: an idle cycle keeps the stored level
  assert_idle_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (ev_i == EV_NONE) |=> $stable(held_q));

  // R5: a conflicting cycle keeps the stored level
  assert_conflict_holds_R5: assert property (@(posedge clk) disable iff (rst)
    (ev_i == EV_CONFLICT) |=> $stable(held_q));

endmodule

// File: rtl/pdec_silence_wdt.sv
module pdec_silence_wdt #(
  parameter int TIMEOUT_CYCLES = 625
) (
  input  logic clk,
  input  logic rst,
  input  logic accept_i,
  output logic lost_o,
  output logic trip_o
);

  localparam int CNT_W = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST_QUIET = CNT_W'(TIMEOUT_CYCLES - 1);

  logic [CNT_W-1:0] quiet_q;
  logic             lost_q;
  logic             at_limit;

  assign at_limit = (quiet_q == LAST_QUIET);
  assign trip_o   = !lost_q && !accept_i && at_limit;

  always_ff @(posedge clk) begin
    if (rst) begin
      quiet_q <= '0;
      lost_q  <= 1'b1;
    end else if (accept_i) begin
      quiet_q <= '0;
      lost_q  <= 1'b0;
    end else if (!lost_q) begin
      if (at_limit) begin
        lost_q <= 1'b1;
      end else begin
        quiet_q <= quiet_q + CNT_W'(1);
      end
    end
  end

  assign lost_o = lost_q;

  // R8: any accepted pulse clears the lost state at the next edge
  assert_pulse_restores_link_R8: assert property (@(posedge clk) disable iff (rst)
    accept_i |=> !lost_q);

  // R6: the lost state never rises in a cycle that carried a pulse
  assert_no_trip_on_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(lost_q) |-> $past(!accept_i));

  // R6: once lost, only a pulse brings the link back
  assert_lost_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (lost_q && !accept_i) |=> lost_q);

endmodule

// File: rtl/pulse_link_receiver.sv
module pulse_link_receiver
  import pdec_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 625
) (
  input  logic clk,
  input  logic rst,
  input  logic set_pulse_i,
  input  logic clr_pulse_i,
  output logic data_o,
  output logic link_lost_o
);

  localparam int RUN_W = $clog2(TIMEOUT_CYCLES + 1) + 1;

  pulse_ev_e ev;
  logic      accept;
  logic      level;
  logic      held;
  logic      lost;
  logic      trip;

  pdec_classifier u_classifier (
    .set_pulse_i (set_pulse_i),
    .clr_pulse_i (clr_pulse_i),
    .ev_o        (ev),
    .accept_o    (accept),
    .level_o     (level)
  );

  pdec_hold_latch #(
    .RESET_LEVEL (1'b1)
  ) u_latch (
    .clk      (clk),
    .rst      (rst),
    .ev_i     (ev),
    .accept_i (accept),
    .level_i  (level),
    .held_o   (held)
  );

  pdec_silence_wdt #(
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
  ) u_wdt (
    .clk      (clk),
    .rst      (rst),
    .accept_i (accept),
    .lost_o   (lost),
    .trip_o   (trip)
  );

  assign data_o      = failsafe_level(lost, held);
  assign link_lost_o = lost;

  // Assertion support: quiet-cycle run length, saturating at the timeout
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= RUN_W'(TIMEOUT_CYCLES);
    end else if (accept) begin
      run_q <= '0;
    end else if (run_q < RUN_W'(TIMEOUT_CYCLES)) begin
      run_q <= run_q + RUN_W'(1);
    end
  end

  // R6: the flag matches the quiet-cycle window exactly
  assert_trip_window_R6: assert property (@(posedge clk) disable iff (rst)
    link_lost_o == (run_q >= RUN_W'(TIMEOUT_CYCLES)));

  // R6: a trip request is always followed by the lost flag
  assert_trip_sets_lost_R6: assert property (@(posedge clk) disable iff (rst)
    trip |=> link_lost_o);

  // R5: a conflicting cycle does not reload the watchdog
  assert_conflict_no_reload_R5: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_CONFLICT && link_lost_o) |=> link_lost_o);

endmodule

// File: tb/test_pulse_link_receiver.sv
module test_pulse_link_receiver;

  localparam int T = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic set_p = 1'b0;
  logic clr_p = 1'b0;
  logic data_o;
  logic link_lost_o;

  always #4 clk = ~clk;

  pulse_link_receiver #(.TIMEOUT_CYCLES(T)) i_pulse_link_receiver (
    .clk         (clk),
    .rst         (rst),
    .set_pulse_i (set_p),
    .clr_pulse_i (clr_p),
    .data_o      (data_o),
    .link_lost_o (link_lost_o)
  );

  typedef struct {
    logic  dat;
    logic  lost;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_vec  = 0;
  int   n_fail = 0;
  bit   done   = 0;

  // Bench model: level last decoded, lost flag, cycles since last pulse
  logic m_level;
  logic m_lost;
  int   m_since;

  task automatic drive(input logic s, input logic c, input logic r, input string tag);
    exp_t e;
    @(negedge clk);
    set_p = s;
    clr_p = c;
    rst   = r;
    if (r) begin
      m_level = 1'b1;
      m_lost  = 1'b1;
      m_since = T;
    end else if (s != c) begin
      m_level = s;
      m_lost  = 1'b0;
      m_since = 0;
    end else begin
      if (m_since < T) m_since++;
      if (m_since >= T) m_lost = 1'b1;
    end
    e.dat  = m_lost ? 1'b1 : m_level;
    e.lost = m_lost;
    e.tag  = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 1'b0, tag);
  endtask

  // Monitor: compare 2 ns after each rising edge
  always @(posedge clk) begin
    exp_t e;
    #2;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      n_vec++;
      if (data_o !== e.dat || link_lost_o !== e.lost) begin
        n_fail++;
        $display("FAIL %s: data_o=%b link_lost_o=%b expected data_o=%b link_lost_o=%b",
                 e.tag, data_o, link_lost_o, e.dat, e.lost);
      end
    end
  end

  initial begin
    // R1: reset state and post-reset silence
    for (int i = 0; i < 3; i++) drive(1'b0, 1'b0, 1'b1, "R1 reset");
    drive(1'b1, 1'b1, 1'b1, "R1 reset ignores pulses");
    idle(4, "R1 before first pulse");
    // R8, R3: first pulse after reset is a clear
    drive(1'b0, 1'b1, 1'b0, "R8 first pulse clear");
    idle(5, "R4 hold low");
    drive(1'b1, 1'b0, 1'b0, "R2 set");
    idle(3, "R4 hold high");
    drive(1'b0, 1'b1, 1'b0, "R3 clear");
    // R9: refresh train of clear pulses
    for (int k = 0; k < 6; k++) begin
      idle(T - 3, "R9 refresh gap");
      drive(1'b0, 1'b1, 1'b0, "R9 refresh clear");
    end
    // R5: conflict does not reload the watchdog; R6 timeout; R7 forced high
    idle(5, "R4 idle before conflict");
    drive(1'b1, 1'b1, 1'b0, "R5 conflict holds low");
    idle(T + 4, "R6 R7 timeout after conflict");
    drive(1'b1, 1'b1, 1'b0, "R5 conflict while lost");
    idle(3, "R7 still lost");
    // R8: recover high, then low
    drive(1'b1, 1'b0, 1'b0, "R8 recover with set");
    drive(1'b0, 1'b1, 1'b0, "R3 clear after recovery");
    drive(1'b1, 1'b0, 1'b0, "R2 alternating set");
    drive(1'b0, 1'b1, 1'b0, "R3 alternating clear");
    // R6: exact boundary, a pulse one cycle before the trip keeps the link
    idle(T - 1, "R6 just under timeout");
    drive(1'b0, 1'b1, 1'b0, "R9 late refresh");
    idle(T + 2, "R6 R7 timeout from low");
    drive(1'b0, 1'b1, 1'b0, "R8 recover with clear");
    idle(2, "R4 hold after recovery");
    // R1: reset in mid-operation
    drive(1'b0, 1'b0, 1'b1, "R1 reset mid run");
    idle(3, "R1 after reset");
    drive(1'b1, 1'b0, 1'b0, "R2 set after reset");
    idle(4, "R4 final");
    @(negedge clk);
    set_p = 1'b0;
    clr_p = 1'b0;
    wait (exp_q.size() == 0);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

endmodule